// File: doc/BRIEF.md
# Per-Target Interrupt Priority Presenter

This block keeps the interrupt state of one processor target and decides when that target's interrupt line is raised. Sources report raise and withdraw events, each carrying a source index, a 4-bit priority and a vector. The block records every raised source, even when its priority is too low to be delivered at the moment. It also tracks which sources the processor has accepted and not yet retired.

Delivery must pass two thresholds. The first is a 4-bit task priority. The second is the priority of the highest interrupt currently in service, so a running handler can only be pre-empted by something strictly more urgent. The processor uses a small strobe-based register port for four operations: set the task priority, retire the current handler (end of interrupt), acknowledge (a read that returns a vector), and set the vector returned when nothing valid can be handed out.

Top module: `irq_presenter`

## Requirements
- R1: The task priority register resets to 15 and keeps only bits 3:0 of a write. It is selected by `reg_sel` = 0 and reads back zero-extended.
- R2: A raise event sets the source's pending bit and records its priority and vector whatever the task priority is. The bit stays set until the source withdraws or is acknowledged.
- R3: A raise event asserts `int_o` when the new priority is strictly greater than both the task priority and the top in-service priority. Otherwise `int_o` keeps its value.
- R4: A withdraw event for a pending source clears its bit. `int_o` then keeps its value only if the top remaining pending priority is strictly above both the task priority and the top in-service priority; otherwise it is cleared. A withdraw for a source that is not pending changes nothing.
- R5: After a task priority write, `int_o` is cleared if the top pending priority is at or below the new value. It is set if the top pending priority exceeds the top in-service priority. Otherwise it is held.
- R6: An acknowledge read (`reg_sel` = 2) always clears `int_o`. With nothing pending it returns the spurious vector.
- R7: If the winning pending source's priority does not exceed the task priority, the acknowledge returns the spurious vector and the source stays pending.
- R8: A successful acknowledge moves the winner from pending to in-service and returns its vector. Every read returns data with `reg_rvalid` high in the cycle after the strobe.
- R9: An end-of-interrupt write (`reg_sel` = 1) with nothing in service has no effect. Otherwise it retires the highest-priority in-service source, then sets `int_o` if a pending source's priority exceeds the new top in-service level (taken as -1 when nothing remains in service).
- R10: Among pending or in-service sources of equal priority, the lowest index is the winner.
- R11: The spurious vector register (`reg_sel` = 3) resets to all ones, is written and read at full vector width, and is the value returned by spurious acknowledges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | Source event strobe |
| src_raise | input | 1 | 1 = raise, 0 = withdraw |
| src_id | input | $clog2(NUM_SRC) | Source index |
| src_prio | input | 4 | Source priority (raise only) |
| src_vec | input | VEC_W | Source vector (raise only) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | 0 task priority, 1 end of interrupt, 2 acknowledge, 3 spurious vector |
| reg_wdata | input | VEC_W | Write data |
| reg_rdata | output | VEC_W | Read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_rd` |
| int_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest situation to reach is a pending source that is hidden rather than lost. It stays pending while the task priority or a nested in-service handler masks it, and it is presented again only when a later task priority write or end of interrupt lowers the bar. The stimulus builds a two-deep nesting through two acknowledges, adds an equal-priority request that must stay hidden, and then retires the handlers one at a time. A spurious acknowledge of a masked source is followed by a task priority drop, which shows that the source survived. Ties at equal priority are created on purpose so that the lowest-index rule decides which vector comes back.

// File: rtl/irqp_pkg.sv
// Shared definitions for the per-target interrupt presenter.
// Assumes priorities are 4 bits; "no source" is represented as priority -1.
package irqp_pkg;
    localparam int PRIO_W = 4;

    typedef enum logic [1:0] {
        SEL_TASKPRI = 2'd0,
        SEL_EOI     = 2'd1,
        SEL_ACK     = 2'd2,
        SEL_SPUR    = 2'd3
    } reg_sel_e;

    // Signed effective priority: -1 when no source is present.
    function automatic logic signed [PRIO_W:0] eff_prio(input logic present,
                                                        input logic [PRIO_W-1:0] p);
        return present ? signed'({1'b0, p}) : -(PRIO_W+1)'(1);
    endfunction
endpackage

// File: rtl/irqp_select.sv
// Highest-priority finder over a bit vector of sources.
// Scans from index 0 upward and replaces the winner only on a strictly
// greater priority, so ties go to the lowest index. Purely combinational.
module irqp_select #(
    parameter int NUM_SRC = 8,
    parameter int PW      = irqp_pkg::PRIO_W,
    localparam int IW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]         bits,
    input  logic [NUM_SRC-1:0][PW-1:0] prio,
    output logic                       found,
    output logic [IW-1:0]              idx,
    output logic [PW-1:0]              top
);
    // Linear scan, strict-greater replacement.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        top   = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (bits[i] && (!found || prio[i] > top)) begin
                found = 1'b1;
                idx   = IW'(i);
                top   = prio[i];
            end
        end
    end
endmodule

// File: rtl/irqp_src_table.sv
// Per-source storage: pending bit, in-service bit, priority and vector.
// Assumes at most one of event / take / retire per cycle (the top gates them).
module irqp_src_table #(
    parameter int NUM_SRC = 8,
    parameter int PW      = irqp_pkg::PRIO_W,
    parameter int VEC_W   = 8,
    localparam int IW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          evt_valid,
    input  logic                          evt_raise,
    input  logic [IW-1:0]                 evt_id,
    input  logic [PW-1:0]                 evt_prio,
    input  logic [VEC_W-1:0]              evt_vec,
    input  logic                          take_valid,
    input  logic [IW-1:0]                 take_id,
    input  logic                          retire_valid,
    input  logic [IW-1:0]                 retire_id,
    output logic [NUM_SRC-1:0]            pend,
    output logic [NUM_SRC-1:0]            insvc,
    output logic [NUM_SRC-1:0][PW-1:0]    prio,
    output logic [NUM_SRC-1:0][VEC_W-1:0] vec
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic hit_evt, hit_take, hit_ret;
        assign hit_evt  = evt_valid    && (evt_id    == IW'(g));
        assign hit_take = take_valid   && (take_id   == IW'(g));
        assign hit_ret  = retire_valid && (retire_id == IW'(g));

        // Pending bit: set/cleared by events, cleared by acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)        pend[g] <= 1'b0;
            else if (hit_evt)  pend[g] <= evt_raise;
            else if (hit_take) pend[g] <= 1'b0;
        end

        // In-service bit: set by acknowledge, cleared by end of interrupt.
        always_ff @(posedge clk) begin
            if (!rst_n)        insvc[g] <= 1'b0;
            else if (hit_take) insvc[g] <= 1'b1;
            else if (hit_ret)  insvc[g] <= 1'b0;
        end

        // Priority and vector captured on every raise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio[g] <= '0;
                vec[g]  <= '0;
            end else if (hit_evt && evt_raise) begin
                prio[g] <= evt_prio;
                vec[g]  <= evt_vec;
            end
        end
    end
endmodule

// File: rtl/irq_presenter.sv
// Per-target interrupt presenter: holds pending and in-service state,
// gates delivery by task priority and nesting level, and serves the
// task-priority, end-of-interrupt, acknowledge and spurious-vector registers.
// Assumes: a register strobe takes precedence; a source event presented in
// the same cycle as reg_wr or reg_rd is dropped.
module irq_presenter #(
    parameter int NUM_SRC            = 8,
    parameter int VEC_W              = 8,
    parameter logic [VEC_W-1:0] SPUR_INIT = '1,
    localparam int PW                = irqp_pkg::PRIO_W,
    localparam int IW                = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_valid,
    input  logic             src_raise,
    input  logic [IW-1:0]    src_id,
    input  logic [PW-1:0]    src_prio,
    input  logic [VEC_W-1:0] src_vec,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_sel,
    input  logic [VEC_W-1:0] reg_wdata,
    output logic [VEC_W-1:0] reg_rdata,
    output logic             reg_rvalid,
    output logic             int_o
);
    import irqp_pkg::*;

    logic [PW-1:0]              ctpr_q;
    logic [VEC_W-1:0]           spur_q;
    logic                       int_q;
    logic [NUM_SRC-1:0]         pend, insvc;
    logic [NUM_SRC-1:0][PW-1:0] prio;
    logic [NUM_SRC-1:0][VEC_W-1:0] vec;

    // Winners of pending set, in-service set, and the two "after removal" sets.
    logic          p_found, s_found, pr_found, sr_found;
    logic [IW-1:0] p_idx, s_idx, pr_idx, sr_idx;
    logic [PW-1:0] p_top, s_top, pr_top, sr_top;

    logic [NUM_SRC-1:0] evt_hot, svc_hot;
    logic               reg_op, evt_go, ack_go, ack_ok, eoi_go, tp_wr;
    logic signed [PW:0] p_eff, s_eff, pr_eff, sr_eff, ctpr_eff, new_eff, tp_new_eff;
    logic               int_d;

    // Decode of register operations and event gating.
    always_comb begin
        reg_op = reg_wr || reg_rd;
        evt_go = src_valid && !reg_op;
        tp_wr  = reg_wr && (reg_sel == SEL_TASKPRI);
        ack_go = reg_rd && (reg_sel == SEL_ACK);
        eoi_go = reg_wr && (reg_sel == SEL_EOI) && s_found;
        evt_hot = NUM_SRC'(1) << src_id;
        svc_hot = NUM_SRC'(1) << s_idx;
    end

    irqp_src_table #(.NUM_SRC(NUM_SRC), .PW(PW), .VEC_W(VEC_W)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_valid    (evt_go),
        .evt_raise    (src_raise),
        .evt_id       (src_id),
        .evt_prio     (src_prio),
        .evt_vec      (src_vec),
        .take_valid   (ack_go && ack_ok),
        .take_id      (p_idx),
        .retire_valid (eoi_go),
        .retire_id    (s_idx),
        .pend         (pend),
        .insvc        (insvc),
        .prio         (prio),
        .vec          (vec)
    );

    irqp_select #(.NUM_SRC(NUM_SRC), .PW(PW)) u_sel_pend (
        .bits(pend), .prio(prio), .found(p_found), .idx(p_idx), .top(p_top));
    irqp_select #(.NUM_SRC(NUM_SRC), .PW(PW)) u_sel_svc (
        .bits(insvc), .prio(prio), .found(s_found), .idx(s_idx), .top(s_top));
    irqp_select #(.NUM_SRC(NUM_SRC), .PW(PW)) u_sel_pend_rem (
        .bits(pend & ~evt_hot), .prio(prio), .found(pr_found), .idx(pr_idx), .top(pr_top));
    irqp_select #(.NUM_SRC(NUM_SRC), .PW(PW)) u_sel_svc_rem (
        .bits(insvc & ~svc_hot), .prio(prio), .found(sr_found), .idx(sr_idx), .top(sr_top));

    // Signed effective priorities used by all threshold comparisons.
    always_comb begin
        p_eff      = eff_prio(p_found, p_top);
        s_eff      = eff_prio(s_found, s_top);
        pr_eff     = eff_prio(pr_found, pr_top);
        sr_eff     = eff_prio(sr_found, sr_top);
        ctpr_eff   = eff_prio(1'b1, ctpr_q);
        new_eff    = eff_prio(1'b1, src_prio);
        tp_new_eff = eff_prio(1'b1, reg_wdata[PW-1:0]);
        ack_ok     = p_found && (p_eff > ctpr_eff);
    end

    // Next value of the interrupt line, one rule per operation.
    always_comb begin
        int_d = int_q;
        if (ack_go) begin
            int_d = 1'b0;
        end else if (tp_wr) begin
            if (p_eff <= tp_new_eff)  int_d = 1'b0;
            else if (p_eff > s_eff)   int_d = 1'b1;
        end else if (eoi_go) begin
            if (p_eff > sr_eff)       int_d = 1'b1;
        end else if (evt_go && src_raise) begin
            if (new_eff > ctpr_eff && new_eff > s_eff) int_d = 1'b1;
        end else if (evt_go && pend[src_id]) begin
            if (!(pr_eff > ctpr_eff && pr_eff > s_eff)) int_d = 1'b0;
        end
    end

    // Interrupt line register.
    always_ff @(posedge clk) begin
        if (!rst_n) int_q <= 1'b0;
        else        int_q <= int_d;
    end

    // Task priority and spurious vector registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctpr_q <= '1;
            spur_q <= SPUR_INIT;
        end else if (reg_wr) begin
            if (reg_sel == SEL_TASKPRI) ctpr_q <= reg_wdata[PW-1:0];
            if (reg_sel == SEL_SPUR)    spur_q <= reg_wdata;
        end
    end

    // Registered read path with one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) begin
                case (reg_sel)
                    SEL_TASKPRI: reg_rdata <= VEC_W'(ctpr_q);
                    SEL_ACK:     reg_rdata <= ack_ok ? vec[p_idx] : spur_q;
                    SEL_SPUR:    reg_rdata <= spur_q;
                    default:     reg_rdata <= '0;
                endcase
            end
        end
    end

    assign int_o = int_q;
endmodule

// File: rtl/irq_presenter_chk.sv
// Property checker for irq_presenter, bound into every instance.
// Assumes the bound instance's internal names ctpr_q, pend, insvc and the
// removal-selector outputs.
module irq_presenter_chk #(
    parameter int NUM_SRC = 8,
    parameter int VEC_W   = 8,
    localparam int IW     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               src_valid,
    input logic               src_raise,
    input logic [IW-1:0]      src_id,
    input logic               reg_wr,
    input logic               reg_rd,
    input logic [1:0]         reg_sel,
    input logic [VEC_W-1:0]   reg_wdata,
    input logic               reg_rvalid,
    input logic               int_o,
    input logic [3:0]         ctpr_q,
    input logic [NUM_SRC-1:0] pend,
    input logic [NUM_SRC-1:0] insvc,
    input logic               pr_found,
    input logic [IW-1:0]      pr_idx,
    input logic               s_found,
    input logic [IW-1:0]      s_idx,
    input logic               sr_found,
    input logic [IW-1:0]      sr_idx
);
    assert_tp_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0) |=> (ctpr_q == $past(reg_wdata[3:0])));

    assert_raise_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_raise && !reg_wr && !reg_rd) |=> pend[$past(src_id)]);

    assert_ack_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_sel == 2'd2) |=> !int_o);

    assert_rvalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    assert_rvalid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);

    assert_svc_grow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(insvc) <= $countones($past(insvc)) + 1));

    assert_eoi_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1 && insvc == '0) |=> $stable(int_o));

    // R4: remaining pending winner is never the withdrawn source.
    assert_rem_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pr_found |-> (pr_idx != src_id));

    // R9: in-service winner after removal differs from the retired source.
    assert_svc_rem_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_found && s_found) |-> (sr_idx != s_idx));
endmodule

bind irq_presenter irq_presenter_chk #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_raise(src_raise),
    .src_id(src_id), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .int_o(int_o),
    .ctpr_q(ctpr_q), .pend(pend), .insvc(insvc),
    .pr_found(pr_found), .pr_idx(pr_idx), .s_found(s_found), .s_idx(s_idx),
    .sr_found(sr_found), .sr_idx(sr_idx));

// File: tb/irq_presenter_tb_top.sv
// Self-checking bench: a stimulus/expectation table walked by one loop,
// then directed checks of reset state and corner cases.
module irq_presenter_tb_top;
    localparam int NSRC = 8;
    localparam int VW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          src_valid = 1'b0, src_raise = 1'b0;
    logic [2:0]    src_id = '0;
    logic [3:0]    src_prio = '0;
    logic [VW-1:0] src_vec = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]    reg_sel = '0;
    logic [VW-1:0] reg_wdata = '0;
    logic [VW-1:0] reg_rdata;
    logic          reg_rvalid, int_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    irq_presenter #(.NUM_SRC(NSRC), .VEC_W(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_raise(src_raise),
        .src_id(src_id), .src_prio(src_prio), .src_vec(src_vec),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .int_o(int_o));

    // Operation codes of the table.
    localparam logic [2:0] OP_RAISE = 3'd0, OP_WDRAW = 3'd1, OP_WTP = 3'd2,
                           OP_EOI = 3'd3, OP_ACK = 3'd4, OP_WSPUR = 3'd5, OP_RTP = 3'd6;

    typedef struct packed {
        logic [2:0] op;
        logic [2:0] id;
        logic [3:0] prio;
        logic [7:0] data;
        logic       exp_int;
        logic       chk_rd;
        logic [7:0] exp_rd;
        logic [3:0] req;
    } step_t;

    localparam int NSTEP = 23;
    localparam step_t STEPS [NSTEP] = '{
        '{OP_RAISE, 3'd2, 4'd5, 8'h22, 1'b0, 1'b0, 8'h00, 4'd2},  // R2: pending below ctpr 15
        '{OP_WTP,   3'd0, 4'd0, 8'h34, 1'b1, 1'b0, 8'h00, 4'd5},  // R5: ctpr 4 presents it
        '{OP_RTP,   3'd0, 4'd0, 8'h00, 1'b1, 1'b1, 8'h04, 4'd1},  // R1: only bits 3:0 kept
        '{OP_RAISE, 3'd5, 4'd5, 8'h55, 1'b1, 1'b0, 8'h00, 4'd3},  // R3
        '{OP_ACK,   3'd0, 4'd0, 8'h00, 1'b0, 1'b1, 8'h22, 4'd10}, // R10: tie -> src 2
        '{OP_RAISE, 3'd6, 4'd5, 8'h66, 1'b0, 1'b0, 8'h00, 4'd3},  // R3: hidden by service
        '{OP_RAISE, 3'd1, 4'd9, 8'h11, 1'b1, 1'b0, 8'h00, 4'd3},  // R3: pre-empts
        '{OP_ACK,   3'd0, 4'd0, 8'h00, 1'b0, 1'b1, 8'h11, 4'd8},  // R8
        '{OP_EOI,   3'd0, 4'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd9},  // R9: still nested at 5
        '{OP_EOI,   3'd0, 4'd0, 8'h00, 1'b1, 1'b0, 8'h00, 4'd9},  // R9: service empty
        '{OP_WDRAW, 3'd5, 4'd0, 8'h00, 1'b1, 1'b0, 8'h00, 4'd4},  // R4: src 6 remains
        '{OP_WTP,   3'd0, 4'd0, 8'h05, 1'b0, 1'b0, 8'h00, 4'd5},  // R5: masked
        '{OP_ACK,   3'd0, 4'd0, 8'h00, 1'b0, 1'b1, 8'hFF, 4'd7},  // R7: spurious
        '{OP_WTP,   3'd0, 4'd0, 8'h02, 1'b1, 1'b0, 8'h00, 4'd7},  // R7: src 6 survived
        '{OP_RAISE, 3'd0, 4'd1, 8'h01, 1'b1, 1'b0, 8'h00, 4'd3},  // R3: low raise holds line
        '{OP_WDRAW, 3'd6, 4'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd4},  // R4: remainder too low
        '{OP_ACK,   3'd0, 4'd0, 8'h00, 1'b0, 1'b1, 8'hFF, 4'd7},  // R7
        '{OP_WDRAW, 3'd0, 4'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd4},  // R4
        '{OP_ACK,   3'd0, 4'd0, 8'h00, 1'b0, 1'b1, 8'hFF, 4'd6},  // R6: nothing pending
        '{OP_EOI,   3'd0, 4'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd9},  // R9: empty service
        '{OP_WSPUR, 3'd0, 4'd0, 8'h3C, 1'b0, 1'b0, 8'h00, 4'd11}, // R11
        '{OP_ACK,   3'd0, 4'd0, 8'h00, 1'b0, 1'b1, 8'h3C, 4'd11}, // R11: new spurious
        '{OP_WDRAW, 3'd3, 4'd0, 8'h00, 1'b0, 1'b0, 8'h00, 4'd4}   // R4: not pending
    };

    task automatic check(input bit ok, input int req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One operation: drive at a falling edge, release at the next, outputs then settled.
    task automatic do_op(input logic [2:0] op, input logic [2:0] id,
                         input logic [3:0] pr, input logic [7:0] d);
        @(negedge clk);
        case (op)
            OP_RAISE: begin src_valid = 1; src_raise = 1; src_id = id; src_prio = pr; src_vec = d; end
            OP_WDRAW: begin src_valid = 1; src_raise = 0; src_id = id; end
            OP_WTP:   begin reg_wr = 1; reg_sel = 2'd0; reg_wdata = d; end
            OP_EOI:   begin reg_wr = 1; reg_sel = 2'd1; reg_wdata = d; end
            OP_ACK:   begin reg_rd = 1; reg_sel = 2'd2; end
            OP_WSPUR: begin reg_wr = 1; reg_sel = 2'd3; reg_wdata = d; end
            OP_RTP:   begin reg_rd = 1; reg_sel = 2'd0; end
            default:  begin reg_rd = 1; reg_sel = 2'd3; end
        endcase
        @(negedge clk);
        src_valid = 0; reg_wr = 0; reg_rd = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R1, R11).
        check(int_o == 0 && reg_rvalid == 0, 1, "reset outputs", int_o, 0);
        do_op(OP_RTP, 0, 0, 0);
        check(reg_rdata == 8'h0F, 1, "ctpr after reset", reg_rdata, 8'h0F);
        do_op(3'd7, 0, 0, 0);
        check(reg_rdata == 8'hFF, 11, "spurious after reset", reg_rdata, 8'hFF);

        // Table walk.
        for (int k = 0; k < NSTEP; k++) begin
            do_op(STEPS[k].op, STEPS[k].id, STEPS[k].prio, STEPS[k].data);
            check(int_o == STEPS[k].exp_int, int'(STEPS[k].req), $sformatf("step %0d int", k),
                  int_o, STEPS[k].exp_int);
            if (STEPS[k].chk_rd)
                check(reg_rvalid && reg_rdata == STEPS[k].exp_rd, int'(STEPS[k].req),
                      $sformatf("step %0d rdata", k), reg_rdata, STEPS[k].exp_rd);
        end

        // R8: valid lasts exactly one cycle.
        do_op(OP_RTP, 0, 0, 0);
        check(reg_rvalid == 1, 8, "rvalid after read", reg_rvalid, 1);
        @(negedge clk);
        check(reg_rvalid == 0, 8, "rvalid drops", reg_rvalid, 0);

        // R4: withdraw of an idle source keeps an asserted line.
        do_op(OP_WTP, 0, 0, 8'h00);
        do_op(OP_RAISE, 3'd4, 4'd7, 8'h44);
        check(int_o == 1, 3, "raise above ctpr 0", int_o, 1);
        do_op(OP_WDRAW, 3'd3, 0, 0);
        check(int_o == 1, 4, "idle withdraw no effect", int_o, 1);
        // R2: source stays pending and is acknowledged.
        do_op(OP_ACK, 0, 0, 0);
        check(reg_rdata == 8'h44 && int_o == 0, 2, "pending kept then acked", reg_rdata, 8'h44);

        // R1/R11: reset again mid-run.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(int_o == 0, 1, "int after reset", int_o, 0);
        do_op(OP_RTP, 0, 0, 0);
        check(reg_rdata == 8'h0F, 1, "ctpr after re-reset", reg_rdata, 8'h0F);
        do_op(OP_ACK, 0, 0, 0);
        check(reg_rdata == 8'hFF, 11, "spurious after re-reset", reg_rdata, 8'hFF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule